// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is a serial-bus target that lets a host read and write a 16-byte configuration page. The page holds four soft-start profile bytes, three control bytes, one reserved byte and eight user bytes. The host uses standard two-wire transactions. A write carries one data byte. A read first sets the memory address with a write phase and then turns the bus around with a repeated START.

Every stored byte appears at once on parallel register outputs, which feed the rest of the chip. The nonvolatile array is modelled with flops. A stored write is followed by a programmable busy period. During that period the block refuses its own device address, so a host can poll for completion. The user bytes are locked unless a protect-release bit in a control byte is set.

The bus lines are open-drain. The block receives the wired-AND level of each line and reports, with a single output, when it pulls SDA low. Both lines pass through a two-flop synchroniser before START and STOP are detected. The protocol logic then runs on the system clock.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The device address is the 7-bit value 1010000 with its last bit replaced by the level of `addr_sel`. It is followed by a read/write bit, where 1 means read. All bytes go MSB first. The block pulls SDA low in the ninth clock only when the address matches.
- R2: After an address that does not match, the block drives nothing, acknowledges nothing and stores nothing until the next START.
- R3: A write is START, device address with bit 0 = 0, memory address, one data byte, then STOP. The block acknowledges all three bytes. The data byte is stored when the STOP arrives.
- R4: A read is START, device address with bit 0 = 0, memory address, repeated START, device address with bit 0 = 1, then one data byte. The block returns the byte at the latched memory address, MSB first.
- R5: The block changes SDA only after a falling edge of SCL. SDA stays stable while SCL is high.
- R6: Memory addresses F0h–F3h are profile bytes 0–3 and appear on `prof_o`, with byte n in bits 8n+7:8n. F4h–F6h are control bytes 0–2 and appear on `ctrl_o` in the same layout. F8h–FFh are user bytes 0–7 and appear on `user_o` in the same layout. Writes to F7h and to any address below F0h are acknowledged and discarded, and reads of them return 00h.
- R7: After reset the profile bytes are 21h, 43h, 65h and 77h. The control bytes are 00h, 08h and 00h. Every user byte is 00h.
- R8: A write to F8h–FFh is acknowledged but discarded unless bit 0 of control byte F5h is 1.
- R9: A write that is actually stored starts a busy period of `BUSY_CYCLES` clocks. During that period the block does not acknowledge its device address. A discarded write starts no busy period.
- R10: A START anywhere in a transaction restarts address reception. A write whose data byte is followed by a repeated START instead of a STOP stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Level of the device address pin, used as address bit 0 |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| prof_o | output | 32 | Soft-start profile bytes F0h–F3h |
| ctrl_o | output | 24 | Control bytes F4h–F6h |
| ctrl_o | output | 24 | Control bytes F4h–F6h |
| user_o | output | 64 | User bytes F8h–FFh |

## Verification
Each bus edge reaches the protocol logic two to three system clocks after the pin moves. The bench therefore holds every bus phase for six clocks. It samples acknowledge and read bits at the end of the SCL high phase, and it also samples each read bit early in the high phase to confirm that SDA was set up after the falling edge. The register outputs change one clock after the synchronised STOP, so they are compared only after the STOP phase has ended. Busy polling probes the device address right after a STOP, well inside the busy window, and probes again once more than `BUSY_CYCLES` clocks have passed.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_MADDR,
    ST_MA_ACK,
    ST_WDATA,
    ST_WD_ACK,
    ST_RD,
    ST_RACK
  } i2c_st_t;

  localparam logic [5:0] DEV_ADDR_HI = 6'b101000;
  localparam logic [3:0] MAP_PAGE    = 4'hF;
  localparam int         NUM_BYTES   = 16;
  localparam int         NUM_PROF    = 4;
  localparam int         NUM_CTRL    = 3;
  localparam int         IDX_RSVD    = 7;
  localparam int         IDX_PROT    = 5;
  localparam int         USER_BASE   = 8;
  localparam int         NUM_USER    = NUM_BYTES - USER_BASE;

  function automatic logic [7:0] default_byte(input int idx);
    case (idx)
      0:       return 8'h21;
      1:       return 8'h43;
      2:       return 8'h65;
      3:       return 8'h77;
      5:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int SR_W = SYNC_STAGES + 1;

  logic [SR_W-1:0] scl_sr, sda_sr;
  logic scl_now, scl_prev, sda_now, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SR_W-2:0], scl_i};
      sda_sr <= {sda_sr[SR_W-2:0], sda_i};
    end
  end

  assign scl_now  = scl_sr[SYNC_STAGES-1];
  assign scl_prev = scl_sr[SYNC_STAGES];
  assign sda_now  = sda_sr[SYNC_STAGES-1];
  assign sda_prev = sda_sr[SYNC_STAGES];

  assign sda_s    = sda_now;
  assign scl_rise = scl_now & ~scl_prev;
  assign scl_fall = ~scl_now & scl_prev;
  assign start_p  = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_p   = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2c_proto.sv
module i2c_proto
  import cfg_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic       busy,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] mem_addr,
  output logic [7:0] wr_data,
  output logic       wr_req
);
  i2c_st_t    state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       rw;
  logic       wr_pend;
  logic       byte_end;
  logic       dev_hit;

  assign byte_end = scl_fall && (cnt == 4'd8);
  assign dev_hit  = (shreg[7:1] == {DEV_ADDR_HI, addr_sel}) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      rw       <= 1'b0;
      wr_pend  <= 1'b0;
      sda_oe   <= 1'b0;
      mem_addr <= '0;
      wr_data  <= '0;
      wr_req   <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      if (start_p) begin
        state   <= ST_DEV;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;
      end else if (stop_p) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        wr_req  <= wr_pend;
        wr_pend <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_MADDR, ST_WDATA: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt <= '0;
              if (state == ST_DEV) begin
                if (dev_hit) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_DEV_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_MADDR) begin
                mem_addr <= shreg;
                sda_oe   <= 1'b1;
                state    <= ST_MA_ACK;
              end else begin
                wr_data <= shreg;
                wr_pend <= 1'b1;
                sda_oe  <= 1'b1;
                state   <= ST_WD_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_MADDR;
              end
            end
          end
          ST_MA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_WD_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_IDLE;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_RACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: an idle (ignoring) slave never pulls the line
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R5: the pull-down only starts right after a synchronised falling edge
  assert_drive_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R9: device address is refused while the array is busy
  assert_nack_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && byte_end && busy && !start_p && !stop_p) |=> !sda_oe);

  // R10: a START always returns to address reception with no pending write
  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (state == ST_DEV && !sda_oe && !wr_pend && !wr_req));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_i2c_pkg::*;
#(
  parameter int BUSY_CYCLES = 20000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_req,
  input  logic [7:0]              addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    busy,
  output logic [8*NUM_PROF-1:0]   prof_o,
  output logic [8*NUM_CTRL-1:0]   ctrl_o,
  output logic [8*NUM_USER-1:0]   user_o
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [7:0]    regs_q [NUM_BYTES];
  logic [3:0]    idx;
  logic          in_page;
  logic          prot_off;
  logic          accept;
  logic [BW-1:0] busy_cnt;

  assign idx      = addr[3:0];
  assign in_page  = (addr[7:4] == MAP_PAGE);
  assign prot_off = regs_q[IDX_PROT][0];
  assign accept   = wr_req && in_page && (int'(idx) != IDX_RSVD) &&
                    ((int'(idx) < USER_BASE) || prot_off);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    if (g == IDX_RSVD) begin : g_rsvd
      assign regs_q[g] = 8'h00;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          regs_q[g] <= default_byte(g);
        else if (accept && idx == 4'(g))     regs_q[g] <= wdata;
      end
    end
  end

  for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
    assign prof_o[8*p +: 8] = regs_q[p];
  end
  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    assign ctrl_o[8*c +: 8] = regs_q[NUM_PROF + c];
  end
  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    assign user_o[8*u +: 8] = regs_q[USER_BASE + u];
  end

  assign rdata = in_page ? regs_q[idx] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (accept)         busy_cnt <= BW'(BUSY_CYCLES);
    else if (busy_cnt != 0)  busy_cnt <= busy_cnt - 1'b1;
  end
  assign busy = (busy_cnt != 0);

  // R9: a stored write is followed by a busy window
  assert_busy_after_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R8: locked user bytes keep their value on a write request
  assert_user_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !prot_off) |=> $stable(user_o));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter int BUSY_CYCLES = 20000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_sel,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [31:0] prof_o,
  output logic [23:0] ctrl_o,
  output logic [63:0] user_o
);
  logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic       busy, wr_req;
  logic [7:0] mem_addr, wr_data, rd_data;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  i2c_proto u_proto (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_sel (addr_sel),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .busy     (busy),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .mem_addr (mem_addr),
    .wr_data  (wr_data),
    .wr_req   (wr_req)
  );

  cfg_regfile #(.BUSY_CYCLES(BUSY_CYCLES)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (wr_req),
    .addr   (mem_addr),
    .wdata  (wr_data),
    .rdata  (rd_data),
    .busy   (busy),
    .prof_o (prof_o),
    .ctrl_o (ctrl_o),
    .user_o (user_o)
  );

endmodule

// File: tb/cfg_i2c_slave_bench.sv
`timescale 1ns/1ps
module cfg_i2c_slave_bench;
  localparam int BUSY = 400;
  localparam int H    = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, addr_sel = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [31:0] prof_o;
  logic [23:0] ctrl_o;
  logic [63:0] user_o;
  assign sda_line = sda_m & ~sda_oe;

  cfg_i2c_slave #(.BUSY_CYCLES(BUSY)) u_cfg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .prof_o(prof_o), .ctrl_o(ctrl_o), .user_o(user_o));

  int vec = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_m [16];

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] ex);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, ex);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(H); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(H);
  endtask
  task automatic bus_stop();
    sda_m = 0; tick(H); scl_m = 1; tick(H); sda_m = 1; tick(2*H);
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1; tick(H); scl_m = 0;
    end
    sda_m = 1; tick(H); scl_m = 1; tick(H); ack = ~sda_line; scl_m = 0;
  endtask
  task automatic recv_byte(output logic [7:0] d, output bit stable);
    logic s0;
    stable = 1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; tick(H); scl_m = 1; tick(2); s0 = sda_line; tick(H-2);
      d[i] = sda_line; if (s0 != d[i]) stable = 0; scl_m = 0;
    end
    sda_m = 1; tick(H); scl_m = 1; tick(H); scl_m = 0;  // master NACK
  endtask

  task automatic probe(input logic [6:0] dev, output bit ack);
    bus_start(); send_byte({dev, 1'b0}, ack); bus_stop();
  endtask
  task automatic write_tx(input logic [6:0] dev, input logic [7:0] ma, input logic [7:0] d,
                          input bit restart, output logic [2:0] acks);
    bit a;
    bus_start();
    send_byte({dev, 1'b0}, a); acks[2] = a;
    send_byte(ma, a); acks[1] = a;
    send_byte(d, a); acks[0] = a;
    if (restart) begin bus_start(); send_byte({dev, 1'b0}, a); end
    bus_stop();
  endtask
  task automatic read_tx(input logic [6:0] dev, input logic [7:0] ma, output logic [7:0] d,
                         output logic [2:0] acks, output bit stable);
    bit a;
    bus_start();
    send_byte({dev, 1'b0}, a); acks[2] = a;
    send_byte(ma, a); acks[1] = a;
    bus_start();
    send_byte({dev, 1'b1}, a); acks[0] = a;
    recv_byte(d, stable);
    bus_stop();
  endtask

  function automatic bit model_store(input logic [7:0] ma, input logic [7:0] d);
    int ix = int'(ma[3:0]);
    if (ma[7:4] == 4'hF && ix != 7 && (ix < 8 || exp_m[5][0])) begin
      exp_m[ix] = d;
      return 1;
    end
    return 0;
  endfunction

  task automatic check_ports(string req);
    logic [31:0] ep; logic [23:0] ec; logic [63:0] eu;
    for (int i = 0; i < 4; i++) ep[8*i +: 8] = exp_m[i];
    for (int i = 0; i < 3; i++) ec[8*i +: 8] = exp_m[4+i];
    for (int i = 0; i < 8; i++) eu[8*i +: 8] = exp_m[8+i];
    chk(prof_o == ep, {req, " prof_o"}, 64'(prof_o), 64'(ep));
    chk(ctrl_o == ec, {req, " ctrl_o"}, 64'(ctrl_o), 64'(ec));
    chk(user_o == eu, {req, " user_o"}, user_o, eu);
  endtask

  // R3 R8 R9: write, then poll the busy window
  task automatic do_write(input logic [7:0] ma, input logic [7:0] d, input string req);
    logic [2:0] acks; bit st, a;
    write_tx(7'h50, ma, d, 0, acks);
    chk(acks == 3'b111, {req, " R3 write acks"}, 64'(acks), 64'h7);
    st = model_store(ma, d);
    check_ports(req);
    probe(7'h50, a);
    chk(a == !st, {req, " R9 poll right after STOP"}, 64'(a), 64'(!st));
    if (st) begin
      tick(BUSY);
      probe(7'h50, a);
      chk(a == 1, {req, " R9 poll after busy window"}, 64'(a), 64'h1);
    end
  endtask

  task automatic do_read(input logic [7:0] ma);
    logic [7:0] d, e; logic [2:0] acks; bit stable;
    e = (ma[7:4] == 4'hF) ? exp_m[ma[3:0]] : 8'h00;
    read_tx(7'h50, ma, d, acks, stable);
    chk(acks == 3'b111, "R4 read acks", 64'(acks), 64'h7);
    chk(d == e, "R4 R6 read data", 64'(d), 64'(e));
    chk(stable, "R5 SDA stable while SCL high", 64'(stable), 64'h1);
  endtask

  initial begin
    logic [7:0] d; logic [2:0] acks; bit a, stable;
    for (int i = 0; i < 16; i++) begin
      case (i)
        0: exp_m[i] = 8'h21; 1: exp_m[i] = 8'h43; 2: exp_m[i] = 8'h65;
        3: exp_m[i] = 8'h77; 5: exp_m[i] = 8'h08; default: exp_m[i] = 8'h00;
      endcase
    end
    tick(5);
    chk(sda_oe == 0, "R7 sda released in reset", 64'(sda_oe), 64'h0);
    rst_n = 1; tick(5);
    check_ports("R7 reset defaults");
    chk(sda_oe == 0, "R7 sda released after reset", 64'(sda_oe), 64'h0);

    // R1: sweep all device addresses for both address-pin levels
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      for (int dv = 0; dv < 128; dv++) begin
        probe(7'(dv), a);
        chk(a == (7'(dv) == {6'b101000, addr_sel}), "R1 address match", 64'(a), 64'(dv));
      end
    end
    addr_sel = 0;

    // R2: a foreign address gets nothing, stores nothing, returns idle line
    write_tx(7'h52, 8'hF0, 8'hAA, 0, acks);
    chk(acks == 3'b000, "R2 foreign write acks", 64'(acks), 64'h0);
    check_ports("R2 after foreign write");
    read_tx(7'h51, 8'hF1, d, acks, stable);
    chk(acks == 3'b000 && d == 8'hFF, "R2 foreign read", {acks, d}, {3'b000, 8'hFF});

    // R10: repeated START instead of STOP stores nothing and starts no busy
    write_tx(7'h50, 8'hF1, 8'h5A, 1, acks);
    check_ports("R10 aborted write");
    probe(7'h50, a);
    chk(a == 1, "R10 no busy after aborted write", 64'(a), 64'h1);

    // R8: user write while locked, then unlock
    do_write(8'hF9, 8'h3C, "R8 locked user write");
    do_write(8'hF5, 8'h09, "R8 unlock");
    for (int i = 0; i < 16; i++)
      if (i != 5) do_write(8'hF0 | 8'(i), 8'(i * 29 + 71), "R6 map write");
    do_write(8'h10, 8'h99, "R6 out-of-page write");

    // R4 R6: read back the whole page and some off-page addresses
    for (int i = 0; i < 16; i++) do_read(8'hF0 | 8'(i));
    do_read(8'h00); do_read(8'h10); do_read(8'h55); do_read(8'hEF);

    // R8: relock and try again
    do_write(8'hF5, 8'h08, "R8 relock");
    do_write(8'hF8, 8'hEE, "R8 relocked user write");
    do_read(8'hF8);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule